// File: doc/BRIEF.md
# Program Counter with Relative Jump and Exception Vector Entry

This unit holds the 16-bit program counter of a small byte-addressed processor whose instructions are one halfword long. Every cycle in which it runs normally it picks the next address from one of three sources. With no control active it is the following instruction. A taken conditional branch adds its short signed halfword offset to pc+2. An unconditional jump does the same with a longer 11-bit signed halfword offset. Jumps therefore reach roughly 2 KB either way, and a target on the far side of a 4 KB boundary is reached like any other. The jump-and-link form also presents pc+2 as a return address, with a write strobe, in the cycle it is taken.

Exceptions do not load the counter directly. When an exception or invalid-instruction request is seen, the unit latches the exception index and enters a vector state. In that state a single bus driver places the index, shifted left by one, on the shared operand bus, and the counter is loaded from that bus value. Reset puts the unit in the same vector state with index 0, so execution starts at address 0x0000. The counter never places its own value on the operand bus.

The control is a two-state machine. `ST_VECTOR` drives the bus and loads pc from it. `ST_RUN` steps, branches or jumps. The transitions are `RUN->VECTOR` on an exception or invalid request, `VECTOR->RUN` always after one cycle, and reset into `VECTOR`.

Top module: `pc_jump_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x0000 and the unit is in the vector state (`bbus_drv`=1, `bbus`=0x0000). In the first cycle after release it still drives vector 0x0000, and pc stays 0x0000.
- R2: In the run state with no request, jump or taken branch, pc advances by 2 at each clock, wrapping from 0xfffe to 0x0000.
- R3: In the run state with `br_taken`=1, `jump`=0 and no request, the next pc is pc+2+2*s, where s is `br_off` read as an 8-bit two's-complement number, taken modulo 2^16.
- R4: In the run state with `jump`=1 and no request, the next pc is pc+2+2*s, where s is `j_off` read as an 11-bit two's-complement number, taken modulo 2^16. This includes the jump from 0x3ffe with offset 1 to 0x4002.
- R5: `link_we` is 1 exactly in run-state cycles with `jump`=1, `link`=1 and no request. In those cycles `link_val` equals pc+2.
- R6: In the run state, `exc_req`=1 or `invalid`=1 keeps pc unchanged for that clock and enters the vector state. In the next cycle `bbus_drv`=1 and `bbus` = `exc_idx`*2, using the index sampled at the request. At the clock after that, pc takes that value.
- R7: Priority in the run state is exception/invalid, then jump, then taken branch, then sequential. A request suppresses `link_we`.
- R8: Whenever `bbus_drv` is 0, `bbus` is 0x0000. No pc value ever appears on it.
- R9: The vector state lasts exactly one cycle. Jump, branch, link and new requests present in that cycle have no effect.
- R10: `link` without `jump` never raises `link_we`, and the branch or sequential step proceeds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request |
| invalid | input | 1 | Invalid-instruction request |
| exc_idx | input | 4 | Exception index, sampled with a request |
| jump | input | 1 | Unconditional relative jump |
| link | input | 1 | Jump also writes the return address |
| j_off | input | 11 | Signed halfword jump offset |
| br_taken | input | 1 | Conditional branch taken |
| br_off | input | 8 | Signed halfword branch offset |
| pc | output | 16 | Program counter |
| link_we | output | 1 | Return-address write strobe |
| link_val | output | 16 | Return address (pc+2) |
| bbus_drv | output | 1 | Vector driver enabled on the operand bus |
| bbus | output | 16 | Operand-bus value from the vector driver |

## Verification
`link_we`, `link_val`, `bbus_drv` and `bbus` are combinational from the current state and inputs. They are due in the same cycle as the stimulus, so the bench reads them 2 ns after driving, well before the next rising edge. A new pc is due one clock after its control is applied and is read at the following falling edge. An exception takes two clocks to reach pc: the request cycle holds pc, and the vector cycle loads it. The bench model advances by exactly that schedule and compares after every clock.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic {
        ST_VECTOR = 1'b0,
        ST_RUN    = 1'b1
    } pcu_state_e;

    typedef enum logic [2:0] {
        SEL_HOLD = 3'd0,
        SEL_SEQ  = 3'd1,
        SEL_BR   = 3'd2,
        SEL_JMP  = 3'd3,
        SEL_BUS  = 3'd4
    } pc_sel_e;

endpackage

// File: rtl/pcu_offset_ext.sv
module pcu_offset_ext #(
    parameter int IN_W  = 11,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  off_in,
    output logic [OUT_W-1:0] off_out
);
    localparam int PAD_W = OUT_W - IN_W - 1;

    // sign-extend then scale from halfwords to bytes
    generate
        if (PAD_W > 0) begin : g_pad
            assign off_out = {{PAD_W{off_in[IN_W-1]}}, off_in, 1'b0};
        end else begin : g_nopad
            assign off_out = {off_in[OUT_W-2:0], 1'b0};
        end
    endgenerate
endmodule

// File: rtl/pcu_target_add.sv
module pcu_target_add #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_cur,
    input  logic [PC_W-1:0] br_disp,
    input  logic [PC_W-1:0] j_disp,
    output logic [PC_W-1:0] pc_seq,
    output logic [PC_W-1:0] pc_br,
    output logic [PC_W-1:0] pc_jmp
);
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

    // all sums wrap modulo 2^PC_W
    always_comb begin
        pc_seq = pc_cur + INSN_BYTES;
        pc_br  = pc_seq + br_disp;
        pc_jmp = pc_seq + j_disp;
    end
endmodule

// File: rtl/pcu_vector_drv.sv
module pcu_vector_drv #(
    parameter int IDX_W = 4,
    parameter int PC_W  = 16
) (
    input  logic             drv_en,
    input  logic [IDX_W-1:0] idx,
    output logic [PC_W-1:0]  bus_out
);
    localparam int VEC_W = IDX_W + 1;

    logic [VEC_W-1:0] vec_raw;

    always_comb begin
        vec_raw = {idx, 1'b0};
        bus_out = drv_en ? PC_W'(vec_raw) : '0;
    end
endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic             invalid,
    input  logic [IDX_W-1:0] exc_idx,
    input  logic             jump,
    input  logic             link,
    input  logic             br_taken,
    output pc_sel_e          pc_sel,
    output logic             vec_drv,
    output logic [IDX_W-1:0] vec_idx,
    output logic             link_we
);
    pcu_state_e       state, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic             take_exc;

    assign take_exc = exc_req | invalid;

    // state register; reset enters the vector state with index 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_VECTOR;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN && take_exc) begin
                idx_q <= exc_idx;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_VECTOR: state_nx = ST_RUN;
            ST_RUN:    state_nx = take_exc ? ST_VECTOR : ST_RUN;
            default:   state_nx = ST_VECTOR;
        endcase
    end

    // outputs
    always_comb begin
        pc_sel  = SEL_SEQ;
        vec_drv = 1'b0;
        link_we = 1'b0;
        unique case (state)
            ST_VECTOR: begin
                vec_drv = 1'b1;
                pc_sel  = SEL_BUS;
            end
            ST_RUN: begin
                if (take_exc) begin
                    pc_sel = SEL_HOLD;
                end else if (jump) begin
                    pc_sel  = SEL_JMP;
                    link_we = link;
                end else if (br_taken) begin
                    pc_sel = SEL_BR;
                end else begin
                    pc_sel = SEL_SEQ;
                end
            end
            default: pc_sel = SEL_HOLD;
        endcase
    end

    assign vec_idx = idx_q;
endmodule

// File: rtl/pc_jump_unit.sv
module pc_jump_unit
    import pcu_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int JOFF_W = 11,
    parameter int BOFF_W = 8,
    parameter int XIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              invalid,
    input  logic [XIDX_W-1:0] exc_idx,
    input  logic              jump,
    input  logic              link,
    input  logic [JOFF_W-1:0] j_off,
    input  logic              br_taken,
    input  logic [BOFF_W-1:0] br_off,
    output logic [PC_W-1:0]   pc,
    output logic              link_we,
    output logic [PC_W-1:0]   link_val,
    output logic              bbus_drv,
    output logic [PC_W-1:0]   bbus
);
    pc_sel_e           sel;
    logic [XIDX_W-1:0] vidx;
    logic [PC_W-1:0]   j_disp, b_disp;
    logic [PC_W-1:0]   nx_seq, nx_br, nx_jmp;
    logic [PC_W-1:0]   pc_q;

    pcu_ctrl #(.IDX_W(XIDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_req  (exc_req),
        .invalid  (invalid),
        .exc_idx  (exc_idx),
        .jump     (jump),
        .link     (link),
        .br_taken (br_taken),
        .pc_sel   (sel),
        .vec_drv  (bbus_drv),
        .vec_idx  (vidx),
        .link_we  (link_we)
    );

    pcu_offset_ext #(.IN_W(JOFF_W), .OUT_W(PC_W)) u_jext (
        .off_in  (j_off),
        .off_out (j_disp)
    );

    pcu_offset_ext #(.IN_W(BOFF_W), .OUT_W(PC_W)) u_bext (
        .off_in  (br_off),
        .off_out (b_disp)
    );

    pcu_target_add #(.PC_W(PC_W)) u_add (
        .pc_cur  (pc_q),
        .br_disp (b_disp),
        .j_disp  (j_disp),
        .pc_seq  (nx_seq),
        .pc_br   (nx_br),
        .pc_jmp  (nx_jmp)
    );

    pcu_vector_drv #(.IDX_W(XIDX_W), .PC_W(PC_W)) u_vdrv (
        .drv_en  (bbus_drv),
        .idx     (vidx),
        .bus_out (bbus)
    );

    // pc register: loaded only from the adder outputs or the operand bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            unique case (sel)
                SEL_HOLD: pc_q <= pc_q;
                SEL_SEQ:  pc_q <= nx_seq;
                SEL_BR:   pc_q <= nx_br;
                SEL_JMP:  pc_q <= nx_jmp;
                SEL_BUS:  pc_q <= bbus;
                default:  pc_q <= pc_q;
            endcase
        end
    end

    assign pc       = pc_q;
    assign link_val = nx_seq;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int PC_W   = 16,
    parameter int JOFF_W = 11,
    parameter int BOFF_W = 8,
    parameter int XIDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req,
    input logic              invalid,
    input logic [XIDX_W-1:0] exc_idx,
    input logic              jump,
    input logic              link,
    input logic [JOFF_W-1:0] j_off,
    input logic              br_taken,
    input logic [BOFF_W-1:0] br_off,
    input logic [PC_W-1:0]   pc,
    input logic              link_we,
    input logic [PC_W-1:0]   link_val,
    input logic              bbus_drv,
    input logic [PC_W-1:0]   bbus
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    logic [PC_W-1:0] j_ext, b_ext;
    assign j_ext = PC_W'(signed'(j_off)) << 1;
    assign b_ext = PC_W'(signed'(br_off)) << 1;

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bbus_drv |-> bbus == '0); // R8

    AST_EXC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bbus_drv && (exc_req || invalid)) |=>
        (bbus_drv && bbus == PC_W'({$past(exc_idx), 1'b0}) && pc == $past(pc))); // R6

    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bbus_drv |=> (!bbus_drv && pc == $past(bbus))); // R9

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!bbus_drv && !exc_req && !invalid && !jump && !br_taken) |=>
        pc == $past(pc) + STEP); // R2

    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bbus_drv && !exc_req && !invalid && jump) |=>
        pc == $past(pc) + STEP + $past(j_ext)); // R4

    AST_BR_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bbus_drv && !exc_req && !invalid && !jump && br_taken) |=>
        pc == $past(pc) + STEP + $past(b_ext)); // R3

    AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (jump && link && !bbus_drv && !exc_req && !invalid
                     && link_val == pc + STEP)); // R5

    AST_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump || !link) |-> !link_we); // R10
endmodule

bind pc_jump_unit pcu_checker #(
    .PC_W(PC_W), .JOFF_W(JOFF_W), .BOFF_W(BOFF_W), .XIDX_W(XIDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exc_req  (exc_req),
    .invalid  (invalid),
    .exc_idx  (exc_idx),
    .jump     (jump),
    .link     (link),
    .j_off    (j_off),
    .br_taken (br_taken),
    .br_off   (br_off),
    .pc       (pc),
    .link_we  (link_we),
    .link_val (link_val),
    .bbus_drv (bbus_drv),
    .bbus     (bbus)
);

// File: tb/sim_pc_jump_unit.sv
module sim_pc_jump_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0, invalid = 1'b0, jump = 1'b0, link = 1'b0, br_taken = 1'b0;
    logic [3:0]  exc_idx = '0;
    logic [10:0] j_off = '0;
    logic [7:0]  br_off = '0;
    logic [15:0] pc, link_val, bbus;
    logic        link_we, bbus_drv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_pc, m_vecval;
    bit          m_vec;

    always #10 clk = ~clk; // 50 MHz

    pc_jump_unit u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .invalid(invalid),
        .exc_idx(exc_idx), .jump(jump), .link(link), .j_off(j_off),
        .br_taken(br_taken), .br_off(br_off), .pc(pc), .link_we(link_we),
        .link_val(link_val), .bbus_drv(bbus_drv), .bbus(bbus)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive after the falling edge, check outputs, advance the model
    task automatic step(input bit x, input bit inv, input int idx, input bit j, input bit l,
                        input int jo, input bit b, input int bo, input string tag);
        bit          exp_lwe, nvec;
        int          sj, sb, t;
        logic [15:0] nx;
        exc_req = x; invalid = inv; exc_idx = idx[3:0]; jump = j; link = l;
        j_off = jo[10:0]; br_off = bo[7:0]; br_taken = b;
        #2;
        exp_lwe = !m_vec && j && l && !(x || inv);
        chk(link_we == exp_lwe, {tag, " R5 link_we"}, int'(link_we), int'(exp_lwe));
        if (exp_lwe) chk(link_val == m_pc + 16'd2, {tag, " R5 link_val"}, int'(link_val), int'(m_pc + 16'd2));
        chk(bbus_drv == m_vec, {tag, " R8 bbus_drv"}, int'(bbus_drv), int'(m_vec));
        chk(bbus == (m_vec ? m_vecval : 16'h0), {tag, " R8 bbus"}, int'(bbus), int'(m_vec ? m_vecval : 16'h0));
        sj = (jo[10:0] >= 11'd1024) ? int'(jo[10:0]) - 2048 : int'(jo[10:0]);
        sb = (bo[7:0] >= 8'd128) ? int'(bo[7:0]) - 256 : int'(bo[7:0]);
        nvec = 1'b0;
        if (m_vec) begin
            nx = m_vecval;
        end else if (x || inv) begin
            nx = m_pc; nvec = 1'b1; m_vecval = 16'(idx[3:0] * 2);
        end else if (j) begin
            t = int'(m_pc) + 2 + 2 * sj; nx = t[15:0];
        end else if (b) begin
            t = int'(m_pc) + 2 + 2 * sb; nx = t[15:0];
        end else begin
            t = int'(m_pc) + 2; nx = t[15:0];
        end
        @(negedge clk);
        chk(pc == nx, {tag, " pc"}, int'(pc), int'(nx));
        m_pc = nx; m_vec = nvec;
    endtask

    task automatic goto_pc(input logic [15:0] target);
        int d, jo;
        while (m_pc != target) begin
            d = int'(target) - int'(m_pc) - 2;
            if (d > 32767) d -= 65536;
            if (d < -32768) d += 65536;
            if (d >= -2048 && d <= 2046) jo = d / 2;
            else jo = (d > 0) ? 1023 : -1024;
            step(0, 0, 0, 1, 0, jo, 0, 0, "R4 goto");
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk(pc == 16'h0, "R1 pc in reset", int'(pc), 0);
        chk(bbus_drv == 1'b1, "R1 driver in reset", int'(bbus_drv), 1);
        chk(bbus == 16'h0, "R1 vector in reset", int'(bbus), 0);
        rst_n = 1'b1;
        m_pc = 16'h0; m_vec = 1'b1; m_vecval = 16'h0;
        // R1: first cycle after release drives vector 0 and keeps pc at 0
        step(0, 0, 0, 1, 1, 100, 1, 5, "R1 first cycle");

        // R2: sequential stepping and wrap
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 seq");
        goto_pc(16'hfff8);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, i + 1, "R2 wrap");

        // R4/R5: every jump offset, link on odd offsets
        for (int o = 0; o < 2048; o++) step(0, 0, 0, 1, o[0], o, o[1], 3, "R4 sweep");

        // R4: crossing a 4 KB boundary
        goto_pc(16'h3ffe);
        step(0, 0, 0, 1, 1, 1, 0, 0, "R4 cross");
        chk(pc == 16'h4002, "R4 cross literal", int'(pc), 32'h4002);

        // R3: every branch offset taken, and untaken with the same offsets
        for (int o = 0; o < 256; o++) step(0, 0, 0, 0, 0, 0, 1, o, "R3 taken");
        for (int o = 0; o < 256; o++) step(0, 0, 0, 0, o[0], 0, 0, o, "R3 untaken R10");

        // R6/R9: every index via both request inputs, junk controls in the vector cycle
        for (int k = 0; k < 32; k++) begin
            step(k[4] == 0, k[4] == 1, k[3:0], k[0], 1, 77, 1, 9, "R6 entry");
            step(1, 1, 15 - k[3:0], 1, 1, 500, 1, 50, "R9 vector cycle");
            step(0, 0, 0, 0, 0, 0, 0, 0, "R6 resume");
        end

        // R7/R10: all combinations of request, jump, branch, link
        for (int c = 0; c < 16; c++) begin
            step(c[3], 0, 3, c[2], c[0], -5, c[1], 20, "R7 priority");
            if (c[3]) step(0, 0, 0, 0, 0, 0, 0, 0, "R7 vector");
        end

        // R1: reset in mid-run
        goto_pc(16'h1234);
        rst_n = 1'b0;
        #2;
        chk(pc == 16'h0, "R1 async reset pc", int'(pc), 0);
        chk(bbus_drv == 1'b1, "R1 async reset driver", int'(bbus_drv), 1);
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = 16'h0; m_vec = 1'b1; m_vecval = 16'h0;
        step(0, 1, 7, 0, 0, 0, 0, 0, "R1 after reset");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule